// File: doc/BRIEF.md
# Arbitrated Graph DMA Loader

This block fills the local graph store of one of two hardware execution monitors with a transition graph copied out of a single shared graph memory. A monitor raises its request line together with a graph identifier. A small arbiter picks one requester. The identifier is translated through a per-graph location table, which holds a base address and an entry count for each graph. The copy engine then streams the graph's entries into the chosen monitor's store at a rate of one entry per clock.

Both monitors share one copy engine. The engine counts as busy for as long as the done output is low. A request that arrives during a copy is held off until the copy completes. When both monitors ask in the same cycle, monitor 1 is served first. The shared memory has one cycle of read latency. A single pipeline stage absorbs it, so the write strobes toward the monitor still arrive back to back.

Top module: `graph_dma_loader`

## Requirements
- R1: While reset is held, done is 1, and grant, the write enables and the shared-memory read enable are all 0.
- R2: Writing a base address and a length into the location table for a graph ID makes a later copy of that ID fetch from that base. Rewriting the entry redirects later copies.
- R3: A copy of length L produces exactly L write strobes on consecutive cycles, with local addresses 0, 1, … L-1 in ascending order. L may be as large as 2^LADDR_W.
- R4: The data of write number i equals the shared-memory word at base + i.
- R5: done falls only while a grant is held. It stays low for the whole copy and rises in the cycle right after the last write strobe. No write strobe appears while done is high.
- R6: At most one grant bit is set. Write strobes go only to wr_en bit m of the granted monitor m (bit 0 is monitor 0, bit 1 is monitor 1).
- R7: When both monitors raise their requests in the same cycle, monitor 1 is granted first. Monitor 0 is served after monitor 1's copy finishes.
- R8: A request that arrives while done is low does not change the grant. It is granted only after done has risen.
- R9: A grant stays set until the cycle after done is seen high with it, and is cleared on the next clock edge.
- R10: A graph of length 0 produces no write strobe and no shared-memory read, and done returns high.
- R11: A copy of length L issues exactly L shared-memory reads, from base up to base + L - 1, and issues no read while done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 2 | Copy request per monitor, held until done is seen with its grant |
| gid_m0 | input | GID_W | Graph ID requested by monitor 0 |
| gid_m1 | input | GID_W | Graph ID requested by monitor 1 |
| grant | output | 2 | One-hot grant to the monitor being served |
| tbl_we | input | 1 | Location table write strobe |
| tbl_gid | input | GID_W | Graph ID of the table entry being written |
| tbl_base | input | CADDR_W | Base address of the graph in shared memory |
| tbl_len | input | LADDR_W+1 | Number of entries in the graph |
| cmem_rd | output | 1 | Shared-memory read enable |
| cmem_addr | output | CADDR_W | Shared-memory read address |
| cmem_rdata | input | DATA_W | Shared-memory read data, one cycle after the address |
| wr_en | output | 2 | Write strobe per monitor local store |
| wr_addr | output | LADDR_W | Local store write address |
| wr_data | output | DATA_W | Local store write data |
| done | output | 1 | High when the engine is idle, low during a copy |

## Verification
The hardest case to reach from the ports is a second request landing in the middle of a long copy. Here the grant must hold still, and the late requester must be picked up only after done has come back. The bench forks two requester processes. One starts a 256-entry copy. The other raises its request ten cycles later. The bench then compares the cycle of the late grant with the cycle of the earlier done rise. A second fork raises both requests in the same cycle to check the priority order, and a zero-length graph checks the path through the engine that skips the copy.

// File: rtl/gdl_pkg.sv
`timescale 1ns/1ps
package gdl_pkg;
  typedef enum logic [1:0] {ARB_FREE, ARB_LAUNCH, ARB_WAIT} arb_state_t;
  typedef enum logic [1:0] {ENG_IDLE, ENG_LOOKUP, ENG_COPY, ENG_DRAIN} eng_state_t;
endpackage

// File: rtl/gdl_arbiter.sv
`timescale 1ns/1ps
module gdl_arbiter #(
  parameter int NREQ  = 2,
  parameter int GID_W = 3,
  parameter int IDX_W = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREQ-1:0]        req,
  input  logic [NREQ*GID_W-1:0]  gid_bus,
  input  logic                   done,
  output logic [NREQ-1:0]        grant,
  output logic                   start,
  output logic [IDX_W-1:0]       owner,
  output logic [GID_W-1:0]       sel_gid
);
  import gdl_pkg::*;

  arb_state_t       st;
  logic [IDX_W-1:0] win_idx;
  logic             any_req;
  logic [GID_W-1:0] win_gid;

  // Highest index wins: later loop iterations override earlier ones.
  always_comb begin
    win_idx = '0;
    any_req = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (req[i]) begin
        win_idx = IDX_W'(i);
        any_req = 1'b1;
      end
    end
  end

  assign win_gid = gid_bus[win_idx*GID_W +: GID_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ARB_FREE;
      grant   <= '0;
      start   <= 1'b0;
      owner   <= '0;
      sel_gid <= '0;
    end else begin
      case (st)
        ARB_FREE: begin
          start <= 1'b0;
          if (done && any_req) begin
            grant   <= NREQ'(1) << win_idx;
            owner   <= win_idx;
            sel_gid <= win_gid;
            start   <= 1'b1;
            st      <= ARB_LAUNCH;
          end
        end
        ARB_LAUNCH: begin
          start <= 1'b0;
          st    <= ARB_WAIT;
        end
        ARB_WAIT: begin
          start <= 1'b0;
          if (done) begin
            grant <= '0;
            st    <= ARB_FREE;
          end
        end
        default: begin
          start <= 1'b0;
          grant <= '0;
          st    <= ARB_FREE;
        end
      endcase
    end
  end
endmodule

// File: rtl/gdl_loc_table.sv
`timescale 1ns/1ps
module gdl_loc_table #(
  parameter int GID_W   = 3,
  parameter int CADDR_W = 10,
  parameter int LEN_W   = 9
) (
  input  logic               clk,
  input  logic               we,
  input  logic [GID_W-1:0]   wgid,
  input  logic [CADDR_W-1:0] wbase,
  input  logic [LEN_W-1:0]   wlen,
  input  logic [GID_W-1:0]   rgid,
  output logic [CADDR_W-1:0] rbase,
  output logic [LEN_W-1:0]   rlen
);
  localparam int DEPTH = 1 << GID_W;
  localparam int ENT_W = CADDR_W + LEN_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;

  // Simple dual-port RAM with registered read.
  always_ff @(posedge clk) begin
    if (we) mem[wgid] <= {wbase, wlen};
    rd_q <= mem[rgid];
  end

  assign {rbase, rlen} = rd_q;
endmodule

// File: rtl/gdl_copy_engine.sv
`timescale 1ns/1ps
module gdl_copy_engine #(
  parameter int NREQ    = 2,
  parameter int IDX_W   = 1,
  parameter int CADDR_W = 10,
  parameter int LADDR_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [IDX_W-1:0]     owner,
  input  logic [CADDR_W-1:0]   loc_base,
  input  logic [LADDR_W:0]     loc_len,
  output logic                 cmem_rd,
  output logic [CADDR_W-1:0]   cmem_addr,
  input  logic [DATA_W-1:0]    cmem_rdata,
  output logic [NREQ-1:0]      wr_en,
  output logic [LADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 done
);
  import gdl_pkg::*;
  localparam int LEN_W = LADDR_W + 1;

  eng_state_t         st;
  logic [IDX_W-1:0]   own_q;
  logic [LEN_W-1:0]   left_q;
  // issue stage (address toward shared memory)
  logic               iss_v, iss_last;
  logic [LADDR_W-1:0] iss_idx;
  logic [CADDR_W-1:0] addr_q;
  // pending stage (waiting for read data)
  logic               pend_v, pend_last;
  logic [LADDR_W-1:0] pend_idx;
  // output stage
  logic               out_last;

  assign cmem_rd   = iss_v;
  assign cmem_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ENG_IDLE;
      done      <= 1'b1;
      own_q     <= '0;
      left_q    <= '0;
      iss_v     <= 1'b0;
      iss_last  <= 1'b0;
      iss_idx   <= '0;
      addr_q    <= '0;
      pend_v    <= 1'b0;
      pend_last <= 1'b0;
      pend_idx  <= '0;
      wr_en     <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      out_last  <= 1'b0;
    end else begin
      pend_v    <= iss_v;
      pend_last <= iss_v & iss_last;
      pend_idx  <= iss_idx;
      wr_en     <= pend_v ? (NREQ'(1) << own_q) : '0;
      wr_addr   <= pend_idx;
      wr_data   <= cmem_rdata;
      out_last  <= pend_last;

      case (st)
        ENG_IDLE: begin
          iss_v <= 1'b0;
          if (start) begin
            own_q <= owner;
            done  <= 1'b0;
            st    <= ENG_LOOKUP;
          end
        end
        ENG_LOOKUP: begin
          if (loc_len == '0) begin
            done <= 1'b1;
            st   <= ENG_IDLE;
          end else begin
            iss_v    <= 1'b1;
            addr_q   <= loc_base;
            iss_idx  <= '0;
            iss_last <= (loc_len == LEN_W'(1));
            left_q   <= loc_len - 1'b1;
            st       <= ENG_COPY;
          end
        end
        ENG_COPY: begin
          if (left_q != '0) begin
            iss_v    <= 1'b1;
            addr_q   <= addr_q + 1'b1;
            iss_idx  <= iss_idx + 1'b1;
            iss_last <= (left_q == LEN_W'(1));
            left_q   <= left_q - 1'b1;
          end else begin
            iss_v    <= 1'b0;
            iss_last <= 1'b0;
            st       <= ENG_DRAIN;
          end
        end
        ENG_DRAIN: begin
          if (out_last) begin
            done <= 1'b1;
            st   <= ENG_IDLE;
          end
        end
        default: begin
          iss_v <= 1'b0;
          done  <= 1'b1;
          st    <= ENG_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/graph_dma_loader.sv
`timescale 1ns/1ps
module graph_dma_loader #(
  parameter int GID_W   = 3,
  parameter int CADDR_W = 10,
  parameter int LADDR_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         req,
  input  logic [GID_W-1:0]   gid_m0,
  input  logic [GID_W-1:0]   gid_m1,
  output logic [1:0]         grant,
  input  logic               tbl_we,
  input  logic [GID_W-1:0]   tbl_gid,
  input  logic [CADDR_W-1:0] tbl_base,
  input  logic [LADDR_W:0]   tbl_len,
  output logic               cmem_rd,
  output logic [CADDR_W-1:0] cmem_addr,
  input  logic [DATA_W-1:0]  cmem_rdata,
  output logic [1:0]         wr_en,
  output logic [LADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               done
);
  localparam int NREQ  = 2;
  localparam int IDX_W = 1;
  localparam int LEN_W = LADDR_W + 1;

  logic               start;
  logic [IDX_W-1:0]   owner;
  logic [GID_W-1:0]   sel_gid;
  logic [CADDR_W-1:0] loc_base;
  logic [LEN_W-1:0]   loc_len;

  gdl_arbiter #(.NREQ(NREQ), .GID_W(GID_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .req(req), .gid_bus({gid_m1, gid_m0}),
    .done(done), .grant(grant), .start(start), .owner(owner),
    .sel_gid(sel_gid)
  );

  gdl_loc_table #(.GID_W(GID_W), .CADDR_W(CADDR_W), .LEN_W(LEN_W)) u_tbl (
    .clk(clk), .we(tbl_we), .wgid(tbl_gid), .wbase(tbl_base), .wlen(tbl_len),
    .rgid(sel_gid), .rbase(loc_base), .rlen(loc_len)
  );

  gdl_copy_engine #(.NREQ(NREQ), .IDX_W(IDX_W), .CADDR_W(CADDR_W),
                    .LADDR_W(LADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .owner(owner),
    .loc_base(loc_base), .loc_len(loc_len),
    .cmem_rd(cmem_rd), .cmem_addr(cmem_addr), .cmem_rdata(cmem_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );
endmodule

// File: rtl/gdl_checker.sv
`timescale 1ns/1ps
module gdl_checker #(
  parameter int LADDR_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         grant,
  input logic [1:0]         wr_en,
  input logic [LADDR_W-1:0] wr_addr,
  input logic               cmem_rd,
  input logic               done
);
  // R6: single grant
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R6: strobes only toward the granted monitor
  p_wr_to_owner_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en & ~grant) == 2'b00);

  // R5: no write while idle
  p_idle_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (wr_en == 2'b00));

  // R5: done only falls with a grant in place
  p_done_fall_granted_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> (grant != 2'b00));

  // R11: no shared-memory read while idle
  p_idle_no_read_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmem_rd);

  // R8: grant frozen while the engine stays busy
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(done)) |-> $stable(grant));

  // R3: back-to-back strobes step the local address by one
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    ((wr_en != 2'b00) && ($past(wr_en) != 2'b00)) |->
      (wr_addr == LADDR_W'($past(wr_addr) + 1'b1)));
endmodule

bind graph_dma_loader gdl_checker #(.LADDR_W(LADDR_W)) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .wr_en(wr_en), .wr_addr(wr_addr),
  .cmem_rd(cmem_rd), .done(done)
);

// File: tb/tb_graph_dma_loader.sv
`timescale 1ns/100ps
module tb_graph_dma_loader;
  localparam int GID_W = 3, CADDR_W = 10, LADDR_W = 8, DATA_W = 32;
  localparam int NVEC = 6;
  // {mon, gid, base, len}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 3'd1, 10'd10,   9'd5},
    {1'b1, 3'd2, 10'd100,  9'd1},
    {1'b0, 3'd5, 10'd1000, 9'd20},
    {1'b1, 3'd7, 10'd0,    9'd3},
    {1'b1, 3'd0, 10'd512,  9'd64},
    {1'b0, 3'd6, 10'd20,   9'd40}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req0 = 1'b0, req1 = 1'b0;
  logic [GID_W-1:0] gid_m0 = '0, gid_m1 = '0;
  logic [1:0] grant;
  logic tbl_we = 1'b0;
  logic [GID_W-1:0] tbl_gid = '0;
  logic [CADDR_W-1:0] tbl_base = '0;
  logic [LADDR_W:0] tbl_len = '0;
  logic cmem_rd;
  logic [CADDR_W-1:0] cmem_addr;
  logic [DATA_W-1:0] cmem_rdata = '0;
  logic [1:0] wr_en;
  logic [LADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic done;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int wcnt [2];
  int log_addr [2][300];
  logic [DATA_W-1:0] log_data [2][300];
  int last_wr_cyc [2];
  int done_rise_cyc = 0;
  int wr_both = 0;
  int rcnt = 0, rfirst = 0, rlast = 0;
  logic prev_done = 1'b1;

  always #2 clk = ~clk;

  graph_dma_loader #(.GID_W(GID_W), .CADDR_W(CADDR_W), .LADDR_W(LADDR_W),
                     .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .req({req1, req0}), .gid_m0(gid_m0), .gid_m1(gid_m1),
    .grant(grant), .tbl_we(tbl_we), .tbl_gid(tbl_gid), .tbl_base(tbl_base),
    .tbl_len(tbl_len), .cmem_rd(cmem_rd), .cmem_addr(cmem_addr),
    .cmem_rdata(cmem_rdata), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done)
  );

  function automatic logic [DATA_W-1:0] cm(input int a);
    logic [9:0] x;
    x = 10'(a);
    return 32'h9E370000 ^ {x, 6'h0, ~x, 6'h0};
  endfunction

  // shared memory model: one cycle read latency
  always @(posedge clk) cmem_rdata <= cm(int'(cmem_addr));

  // port observer
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (wr_en == 2'b11) wr_both = wr_both + 1;
      for (int m = 0; m < 2; m++) begin
        if (wr_en[m]) begin
          if (wcnt[m] < 300) begin
            log_addr[m][wcnt[m]] = int'(wr_addr);
            log_data[m][wcnt[m]] = wr_data;
          end
          wcnt[m] = wcnt[m] + 1;
          last_wr_cyc[m] = cyc;
        end
      end
      if (cmem_rd) begin
        if (rcnt == 0) rfirst = int'(cmem_addr);
        rlast = int'(cmem_addr);
        rcnt = rcnt + 1;
      end
      if (done && !prev_done) done_rise_cyc = cyc;
    end
    prev_done = done;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic prog(input int g, input int base, input int len);
    @(negedge clk); #1;
    tbl_we = 1'b1; tbl_gid = GID_W'(g); tbl_base = CADDR_W'(base);
    tbl_len = (LADDR_W+1)'(len);
    @(negedge clk); #1;
    tbl_we = 1'b0;
  endtask

  task automatic run_xfer(input int mon, input int g, input int base,
                          input int len, input bit solo,
                          output int gcyc, output int dcyc);
    bit seen_low;
    int bad;
    int first_bad;
    @(negedge clk); #1;
    wcnt[mon] = 0;
    if (solo) begin
      wcnt[1-mon] = 0;
      rcnt = 0;
    end
    if (mon == 0) begin req0 = 1'b1; gid_m0 = GID_W'(g); end
    else          begin req1 = 1'b1; gid_m1 = GID_W'(g); end
    seen_low = 1'b0;
    gcyc = -1;
    forever begin
      @(negedge clk); #1;
      if (grant[mon] && gcyc < 0) gcyc = cyc;
      if (grant[mon] && !done) seen_low = 1'b1;
      if (grant[mon] && done && seen_low) break;
    end
    if (mon == 0) req0 = 1'b0; else req1 = 1'b0;
    dcyc = done_rise_cyc;

    chk(wcnt[mon] == len, "R3", "write strobe count", wcnt[mon], len);
    bad = 0; first_bad = -1;
    for (int i = 0; i < len && i < 300; i++)
      if (log_addr[mon][i] != i) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, "R3", "local address order, first bad index", first_bad, -1);
    bad = 0; first_bad = -1;
    for (int i = 0; i < len && i < 300; i++)
      if (log_data[mon][i] !== cm(base + i)) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, "R4", "data vs shared word at base+i (R2 lookup), first bad index",
        first_bad, -1);
    if (len > 0)
      chk(dcyc == last_wr_cyc[mon] + 1, "R5", "done rise cycle", dcyc,
          last_wr_cyc[mon] + 1);
    else
      chk(wcnt[mon] == 0 && done, "R10", "zero-length writes", wcnt[mon], 0);
    if (solo) begin
      chk(wcnt[1-mon] == 0, "R6", "strobes toward other monitor", wcnt[1-mon], 0);
      chk(rcnt == len, "R11", "shared read count", rcnt, len);
      if (len > 0) begin
        chk(rfirst == base, "R11", "first read address", rfirst, base);
        chk(rlast == base + len - 1, "R11", "last read address", rlast, base + len - 1);
      end
    end
    @(negedge clk); #1;
    chk(grant[mon] == 1'b0, "R9", "grant after release", grant[mon], 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk = nchk + 1; nfail = nfail + 1;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int g0, d0, g1, d1;
    wcnt[0] = 0; wcnt[1] = 0;
    last_wr_cyc[0] = 0; last_wr_cyc[1] = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(done == 1'b1, "R1", "done in reset", done, 1);
    chk(grant == 2'b00, "R1", "grant in reset", grant, 0);
    chk(wr_en == 2'b00, "R1", "wr_en in reset", wr_en, 0);
    chk(cmem_rd == 1'b0, "R1", "cmem_rd in reset", cmem_rd, 0);
    @(negedge clk); #1;
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++)
      prog(int'(VEC[v][21:19]), int'(VEC[v][18:9]), int'(VEC[v][8:0]));
    prog(3, 300, 0);
    prog(4, 700, 256);

    // table-driven single transfers
    for (int v = 0; v < NVEC; v++)
      run_xfer(int'(VEC[v][22]), int'(VEC[v][21:19]), int'(VEC[v][18:9]),
               int'(VEC[v][8:0]), 1'b1, g0, d0);

    // R2: rewriting a table entry redirects the next copy
    prog(1, 900, 7);
    run_xfer(0, 1, 900, 7, 1'b1, g0, d0);

    // R10: zero-length graph
    run_xfer(0, 3, 300, 0, 1'b1, g0, d0);

    // R3: largest length, local address runs to the top of the store
    run_xfer(1, 4, 700, 256, 1'b1, g0, d0);

    // R7: simultaneous requests
    fork
      run_xfer(0, 6, 20, 40, 1'b0, g0, d0);
      run_xfer(1, 2, 100, 1, 1'b0, g1, d1);
    join
    chk(g1 < g0, "R7", "monitor 1 grant cycle before monitor 0", g1, g0);
    chk(g0 > d1, "R7", "monitor 0 grant after monitor 1 done", g0, d1 + 1);

    // R8: late request during a long copy waits
    fork
      run_xfer(0, 4, 700, 256, 1'b0, g0, d0);
      begin
        repeat (10) @(negedge clk);
        run_xfer(1, 7, 0, 3, 1'b0, g1, d1);
      end
    join
    chk(g1 > d0, "R8", "late grant cycle after first done", g1, d0 + 1);
    chk(wr_both == 0, "R6", "cycles with both strobes", wr_both, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule